// File: doc/BRIEF.md
# Multi-Port Sensor Polling Sequencer

This block walks, one at a time, through the temperature sensors on two serial-bus ports. For each sensor that is present and enabled, it drives four commands in turn to a bus-engine request interface: set mode, write address, initiate read and read temperature. After each command it waits until the engine raises its completion interrupt or until a bounded number of ticks has passed. It then judges the step by the completion flag and the return code the engine reports.

All sequencing moves forward on a tick pulse. The bench or the system supplies that pulse together with a free-running 4-bit tick value. A new sensor transaction may begin only in two tick slots. Each sensor has a saturating count of consecutive errors. When a sensor fails, the block pulses a reset request and holds a cause word that says which sensor failed and why. The block then moves on to the next sensor. The engine, the wire protocol and the reset procedure itself live outside this block.

Top module: `sensor_poll_seq`

## Requirements
- R1: Every command strobe carries device address 0x30 OR (sensor index shifted left by one), where the index is the one shown on `cmd_idx_o`.
- R2: Step codes are 0 = set mode, 1 = write address, 2 = initiate read, 3 = read temperature. A sensor's steps are issued in the order 0, 1, 2, 3, and the position does not change while they are issued.
- R3: A present, enabled sensor leaves the idle scan and starts its transaction only on a tick whose value is 0 or 8.
- R4: After a strobe, the step resolves on the first tick with the interrupt high. Without the interrupt, it resolves on the third tick. A step succeeds when completion is high and the return code is 0.
- R5: After the last index of a port, the position moves to index 0 of the other port. Arriving at port 0 index 0 pulses `round_done_o` for one cycle.
- R6: A sensor whose presence bit is 0 or whose disable bit is 1 issues no command, and the position advances by one on that tick. Mask bit number = port*SENSORS_PER_PORT + index.
- R7: A failed initiate-read or read step is issued again, up to 3 attempts in total. A failed set-mode or write-address step fails the sensor at once.
- R8: Each sensor's 8-bit error count increments when the sensor fails, holds at 255, and clears after a successful read step.
- R9: When a sensor fails, `reset_req_o` pulses for one cycle. The cause word then holds the port in bits 31:24, the index in bits 23:16 and return code bits 15:0. The position then advances to the next sensor.
- R10: A strobe is issued only on a tick with `engine_idle_i` high. Otherwise the same step waits for the next tick.
- R11: After reset, the position is port 0 index 0, all error counts are 0, and no strobe, round pulse or reset request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_pulse_i | input | 1 | One-cycle pulse that advances the sequencer |
| tick_i | input | 4 | Free-running tick value |
| present_i | input | 2*SENSORS_PER_PORT | Sensor presence mask |
| disable_i | input | 2*SENSORS_PER_PORT | Sensor disable mask |
| engine_idle_i | input | 1 | Bus engine can accept a command |
| irq_i | input | 1 | Engine completion interrupt |
| done_i | input | 1 | Last request completed |
| rc_i | input | 16 | Return code of the last request |
| cmd_vld_o | output | 1 | Command strobe |
| cmd_step_o | output | 2 | Step code |
| cmd_port_o | output | 1 | Current port |
| cmd_idx_o | output | IDX_W | Current sensor index |
| cmd_addr_o | output | 8 | Device address |
| round_done_o | output | 1 | Round-complete pulse |
| reset_req_o | output | 1 | Reset request pulse |
| reset_cause_o | output | 32 | Cause of last failure |
| err_cnt_o | output | 16*SENSORS_PER_PORT | Packed per-sensor error counts, sensor k in bits 8k+7:8k |

## Verification
On every cycle, the assertions check four things:
- a strobe comes only from a tick that found the engine idle;
- reset requests and strobes follow tick pulses and never coincide;
- a round pulse lands at port 0 index 0, and the position holds still through the later steps of a transaction;
- error counts only step up by one, hold, or return to zero.

The tick-slot gating, the step order, the retry limit, the exact cause word, saturation at 255 and the skipping of masked sensors depend on input history. Only the bench's scenarios show these, through its reference model: long runs of forced failures, masks that change, a busy engine and interrupts that never come.

// File: rtl/sensor_poll_seq.sv
module sensor_poll_seq #(
  parameter int SENSORS_PER_PORT = 4,
  parameter int MAX_WAIT = 2,
  parameter int MAX_TRIES = 3,
  localparam int NS = 2 * SENSORS_PER_PORT,
  localparam int IDX_W = (SENSORS_PER_PORT > 1) ? $clog2(SENSORS_PER_PORT) : 1,
  localparam int SEL_W = $clog2(NS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_pulse_i,
  input  logic [3:0]           tick_i,
  input  logic [NS-1:0]        present_i,
  input  logic [NS-1:0]        disable_i,
  input  logic                 engine_idle_i,
  input  logic                 irq_i,
  input  logic                 done_i,
  input  logic [15:0]          rc_i,
  output logic                 cmd_vld_o,
  output logic [1:0]           cmd_step_o,
  output logic                 cmd_port_o,
  output logic [IDX_W-1:0]     cmd_idx_o,
  output logic [7:0]           cmd_addr_o,
  output logic                 round_done_o,
  output logic                 reset_req_o,
  output logic [31:0]          reset_cause_o,
  output logic [NS*8-1:0]      err_cnt_o
);
  localparam int TRY_W = $clog2(MAX_TRIES + 1);
  localparam int NR_W  = $clog2(MAX_WAIT + 2);
  localparam logic [1:0] STEP_MODE = 2'd0, STEP_INIT = 2'd2, STEP_READ = 2'd3;

  typedef enum logic [1:0] {ST_SCAN, ST_ISSUE, ST_WAIT} st_t;

  st_t              st_q;
  logic             port_q;
  logic [IDX_W-1:0] idx_q;
  logic [1:0]       step_q;
  logic [TRY_W-1:0] try_q;
  logic [NR_W-1:0]  nr_q;
  logic             vld_q, round_q, rreq_q;
  logic [31:0]      cause_q;
  logic [7:0]       err_q [NS];

  logic [SEL_W-1:0] sel;
  logic             skip, slot, proceed, ok, retry, last_idx;

  assign sel      = port_q ? SEL_W'(SENSORS_PER_PORT) + SEL_W'(idx_q) : SEL_W'(idx_q);
  assign skip     = !present_i[sel] || disable_i[sel];
  assign slot     = (tick_i == 4'd0) || (tick_i == 4'd8);
  assign proceed  = irq_i || (nr_q >= NR_W'(MAX_WAIT));
  assign ok       = done_i && (rc_i == 16'd0);
  assign retry    = (step_q >= STEP_INIT) && (try_q < TRY_W'(MAX_TRIES));
  assign last_idx = (idx_q == IDX_W'(SENSORS_PER_PORT - 1));

  assign cmd_vld_o     = vld_q;
  assign cmd_step_o    = step_q;
  assign cmd_port_o    = port_q;
  assign cmd_idx_o     = idx_q;
  assign cmd_addr_o    = 8'h30 | (8'(idx_q) << 1);
  assign round_done_o  = round_q;
  assign reset_req_o   = rreq_q;
  assign reset_cause_o = cause_q;

  for (genvar k = 0; k < NS; k++) begin : g_err_out
    assign err_cnt_o[k*8 +: 8] = err_q[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_SCAN;
      port_q  <= 1'b0;
      idx_q   <= '0;
      step_q  <= STEP_MODE;
      try_q   <= '0;
      nr_q    <= '0;
      vld_q   <= 1'b0;
      round_q <= 1'b0;
      rreq_q  <= 1'b0;
      cause_q <= '0;
      for (int k = 0; k < NS; k++) err_q[k] <= 8'd0;
    end else begin
      vld_q   <= 1'b0;
      round_q <= 1'b0;
      rreq_q  <= 1'b0;
      if (tick_pulse_i) begin
        unique case (st_q)
          ST_SCAN: begin
            if (skip) begin
              if (last_idx) begin
                port_q  <= ~port_q;
                idx_q   <= '0;
                round_q <= port_q;
              end else begin
                idx_q <= idx_q + 1'b1;
              end
            end else if (slot) begin
              st_q   <= ST_ISSUE;
              step_q <= STEP_MODE;
              try_q  <= '0;
            end
          end
          ST_ISSUE: begin
            if (engine_idle_i) begin
              vld_q <= 1'b1;
              try_q <= try_q + 1'b1;
              nr_q  <= '0;
              st_q  <= ST_WAIT;
            end
          end
          ST_WAIT: begin
            if (!irq_i) nr_q <= nr_q + 1'b1;
            if (proceed) begin
              if (ok) begin
                if (step_q == STEP_READ) begin
                  err_q[sel] <= 8'd0;
                  st_q       <= ST_SCAN;
                  if (last_idx) begin
                    port_q  <= ~port_q;
                    idx_q   <= '0;
                    round_q <= port_q;
                  end else begin
                    idx_q <= idx_q + 1'b1;
                  end
                end else begin
                  step_q <= step_q + 1'b1;
                  try_q  <= '0;
                  st_q   <= ST_ISSUE;
                end
              end else if (retry) begin
                st_q <= ST_ISSUE;
              end else begin
                if (err_q[sel] != 8'hFF) err_q[sel] <= err_q[sel] + 1'b1;
                rreq_q  <= 1'b1;
                cause_q <= {8'(port_q), 8'(idx_q), rc_i};
                st_q    <= ST_SCAN;
                if (last_idx) begin
                  port_q  <= ~port_q;
                  idx_q   <= '0;
                  round_q <= port_q;
                end else begin
                  idx_q <= idx_q + 1'b1;
                end
              end
            end
          end
          default: st_q <= ST_SCAN;
        endcase
      end
    end
  end
endmodule

module sensor_poll_seq_chk #(
  parameter int NS = 8,
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_pulse_i,
  input logic             engine_idle_i,
  input logic             cmd_vld_o,
  input logic [1:0]       cmd_step_o,
  input logic             cmd_port_o,
  input logic [IDX_W-1:0] cmd_idx_o,
  input logic             round_done_o,
  input logic             reset_req_o,
  input logic [NS*8-1:0]  err_cnt_o
);
  // R10
  strobe_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld_o |-> $past(tick_pulse_i && engine_idle_i));

  // R9
  reset_req_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req_o |-> ($past(tick_pulse_i) && !cmd_vld_o));

  // R5
  round_at_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    round_done_o |-> (cmd_port_o == 1'b0 && cmd_idx_o == '0));

  // R2
  position_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld_o && cmd_step_o != 2'd0) |-> ($stable(cmd_port_o) && $stable(cmd_idx_o)));

  for (genvar k = 0; k < NS; k++) begin : g_err_chk
    // R8
    err_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_cnt_o[k*8 +: 8] != $past(err_cnt_o[k*8 +: 8])) |->
        (err_cnt_o[k*8 +: 8] == 8'd0 || err_cnt_o[k*8 +: 8] == $past(err_cnt_o[k*8 +: 8]) + 8'd1));
  end
endmodule

bind sensor_poll_seq sensor_poll_seq_chk #(.NS(NS), .IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick_pulse_i(tick_pulse_i), .engine_idle_i(engine_idle_i),
  .cmd_vld_o(cmd_vld_o), .cmd_step_o(cmd_step_o), .cmd_port_o(cmd_port_o),
  .cmd_idx_o(cmd_idx_o), .round_done_o(round_done_o), .reset_req_o(reset_req_o),
  .err_cnt_o(err_cnt_o)
);

// File: tb/sensor_poll_seq_tb_top.sv
module sensor_poll_seq_tb_top;
  localparam int SPP = 4;
  localparam int NS = 2 * SPP;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_pulse = 1'b0;
  logic [3:0] tick_v = 4'd0;
  logic [NS-1:0] present = '1, disable_m = '0;
  logic idle = 1'b1, irq = 1'b0, done = 1'b0;
  logic [15:0] rc = 16'd0;
  logic cmd_vld, cmd_port, round_done, reset_req;
  logic [1:0] cmd_step;
  logic [1:0] cmd_idx;
  logic [7:0] cmd_addr;
  logic [31:0] reset_cause;
  logic [NS*8-1:0] err_cnt;

  int n_checks = 0, n_errors = 0, rounds_seen = 0;

  always #4 clk = ~clk;

  sensor_poll_seq #(.SENSORS_PER_PORT(SPP)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_pulse_i(tick_pulse), .tick_i(tick_v),
    .present_i(present), .disable_i(disable_m), .engine_idle_i(idle), .irq_i(irq),
    .done_i(done), .rc_i(rc), .cmd_vld_o(cmd_vld), .cmd_step_o(cmd_step),
    .cmd_port_o(cmd_port), .cmd_idx_o(cmd_idx), .cmd_addr_o(cmd_addr),
    .round_done_o(round_done), .reset_req_o(reset_req), .reset_cause_o(reset_cause),
    .err_cnt_o(err_cnt)
  );

  // reference model state
  int m_st = 0, m_port = 0, m_idx = 0, m_step = 0, m_try = 0, m_nr = 0;
  int m_err [NS];
  logic [31:0] m_cause = 0;
  bit e_vld, e_round, e_rr;

  task automatic check(input bit cond, input string req, input longint act, input longint exp);
    n_checks++;
    if (!cond) begin
      n_errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_addr(input int i);
    return 8'h30 | 8'(i << 1);
  endfunction

  task automatic m_advance();
    if (m_idx == SPP - 1) begin
      e_round = (m_port == 1);
      m_port = 1 - m_port;
      m_idx = 0;
    end else m_idx++;
  endtask

  task automatic model_tick();
    int s;
    s = m_port * SPP + m_idx;
    e_vld = 0; e_round = 0; e_rr = 0;
    case (m_st)
      0: if (!present[s] || disable_m[s]) m_advance();
         else if (tick_v == 0 || tick_v == 8) begin m_st = 1; m_step = 0; m_try = 0; end
      1: if (idle) begin e_vld = 1; m_try++; m_nr = 0; m_st = 2; end
      default: begin
        bit go;
        go = irq || (m_nr >= 2);
        if (!irq) m_nr++;
        if (go) begin
          if (done && rc == 0) begin
            if (m_step == 3) begin m_err[s] = 0; m_st = 0; m_advance(); end
            else begin m_step++; m_try = 0; m_st = 1; end
          end else if (m_step >= 2 && m_try < 3) m_st = 1;
          else begin
            if (m_err[s] < 255) m_err[s]++;
            e_rr = 1;
            m_cause = {8'(m_port), 8'(m_idx), rc};
            m_st = 0;
            m_advance();
          end
        end
      end
    endcase
  endtask

  task automatic compare();
    logic [NS*8-1:0] exp_err;
    for (int k = 0; k < NS; k++) exp_err[k*8 +: 8] = 8'(m_err[k]);
    check(cmd_vld == e_vld, "R10/R3 strobe", cmd_vld, e_vld);
    if (e_vld && cmd_vld) begin
      check(cmd_step == 2'(m_step), "R2 step code", cmd_step, m_step);
      check(cmd_addr == exp_addr(m_idx), "R1 address", cmd_addr, exp_addr(m_idx));
    end
    check(cmd_port == 1'(m_port) && cmd_idx == 2'(m_idx), "R5/R6 position",
          {cmd_port, cmd_idx}, {1'(m_port), 2'(m_idx)});
    check(round_done == e_round, "R5 round pulse", round_done, e_round);
    if (round_done) rounds_seen++;
    check(reset_req == e_rr, "R9 reset request", reset_req, e_rr);
    if (e_rr) check(reset_cause == m_cause, "R9 cause word", reset_cause, m_cause);
    check(err_cnt == exp_err, "R8 error counts", err_cnt, exp_err);
  endtask

  task automatic do_tick();
    @(negedge clk);
    tick_pulse = 1'b1;
    model_tick();
    @(negedge clk);
    tick_pulse = 1'b0;
    compare();
    tick_v = tick_v + 4'd1;
  endtask

  initial begin
    #(8ns * 200000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < NS; k++) m_err[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(!cmd_vld && !round_done && !reset_req, "R11 idle outputs", {cmd_vld, round_done, reset_req}, 0);
    check(cmd_port == 0 && cmd_idx == 0, "R11 position", {cmd_port, cmd_idx}, 0);
    check(err_cnt == '0, "R11 error counts", err_cnt, 0);

    // clean polling, all sensors (R1 R2 R4 R5)
    irq = 1; done = 1; rc = 0; idle = 1;
    for (int t = 0; t < 300; t++) do_tick();
    check(rounds_seen > 0, "R5 rounds completed", rounds_seen, 1);

    // no interrupt: timeout path (R4), busy engine (R10)
    irq = 0;
    for (int t = 0; t < 200; t++) begin
      idle = (t % 5) != 0;
      do_tick();
    end
    idle = 1; irq = 1;

    // mask changes (R6)
    present = 8'b1010_0110; disable_m = 8'b0000_0100;
    for (int t = 0; t < 200; t++) do_tick();

    // saturation: only sensor 0, always failing (R7 R8 R9)
    present = 8'b0000_0001; disable_m = '0; rc = 16'hBEEF;
    for (int t = 0; t < 5000; t++) do_tick();
    check(err_cnt[7:0] == 8'd255, "R8 saturation", err_cnt[7:0], 255);
    rc = 16'd0;
    for (int t = 0; t < 60; t++) do_tick();
    check(err_cnt[7:0] == 8'd0, "R8 clear on read", err_cnt[7:0], 0);

    // constrained random
    present = '1;
    for (int t = 0; t < 3000; t++) begin
      if ($urandom % 100 == 0) present = 8'($urandom) | 8'h01;
      if ($urandom % 100 == 0) disable_m = 8'($urandom) & 8'hFE;
      irq  = ($urandom % 4) != 0;
      done = ($urandom % 8) != 0;
      rc   = (($urandom % 6) == 0) ? 16'($urandom | 1) : 16'd0;
      idle = ($urandom % 6) != 0;
      do_tick();
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule